// File: doc/BRIEF.md
# PWM Timebase with Deferred Prescaler

This block is the time reference for a pulse-width modulator. A free-running up-counter advances once per prescaled tick. The tick comes from one of two clock-enable streams, a slow one and a fast one, picked by a select input. Both streams are single-cycle enable pulses on the one system clock. A software-written 3-bit code sets how many timer ticks make one counter step. The counter wraps at its all-ones value, and the wrap marks the end of a PWM cycle, which the block reports with a one-cycle pulse.

The prescale code is shadowed. While the timer runs, the divide ratio in effect is held for the whole PWM cycle. At the wrap it reloads from whatever code is present on the input at that moment, so a ratio never changes in the middle of a cycle. While the timer is stopped, the counter and the prescale sub-counter are held at zero and the active code tracks the input. Starting the timer therefore always begins a clean cycle.

Top module: `pwm_timebase`

## Requirements
- R1: Under reset (rst_n low), count is 0, wrap_pulse is 0 and ps_active is 0.
- R2: While run is 1, count increases by exactly one on every prescaled tick and is unchanged otherwise. A prescaled tick is every (c+1)-th selected timer tick, where c is the value of ps_active (code 0 divides by 1, code 7 by 8).
- R3: With src_sel at 0 the timer ticks on slow_en only. With src_sel at 1 it ticks on fast_en only. The unselected enable has no effect on count.
- R4: While run stays 1, ps_active changes only on the clock edge where count wraps from all ones to 0. There it takes the ps_code value present at that edge, so several writes within one cycle leave only the last one in force.
- R5: wrap_pulse is high for exactly one clock, in the cycle right after the edge where count wraps from all ones (0xFFF by default) to 0, and is low at all other times.
- R6: While run is 0, count and the prescale sub-counter are held at 0, wrap_pulse is 0, and ps_active equals the ps_code sampled at the previous clock edge.
- R7: The prescale sub-counter restarts at the wrap. After a wrap with new code c, count reaches 1 after exactly c+1 selected ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Timer run control |
| src_sel | input | 1 | Timer clock source: 0 slow, 1 fast |
| slow_en | input | 1 | Slow timer-clock enable pulse |
| fast_en | input | 1 | Fast timer-clock enable pulse |
| ps_code | input | PS_W (3) | Prescale code written by software |
| count | output | CNT_W (12) | Timebase counter value |
| wrap_pulse | output | 1 | One-cycle end-of-PWM-cycle pulse |
| ps_active | output | PS_W (3) | Prescale code currently in effect |

## Verification
The bench builds the block with its default parameters: a 12-bit counter and a 3-bit prescale code. With the fast enable held high, a whole PWM cycle takes 4096 clocks at divide-by-1 and 12288 clocks at divide-by-3. That is short enough to reach real wraps, shadow reloads taken from mid-cycle writes, and the restart of the sub-counter under a new factor. Random enable streams, source switching, start and stop, and code changes then exercise the per-tick stepping at every divide factor.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Divide ratio produced by a prescale code: code n divides by n+1.
  function automatic int unsigned div_of_code(input int unsigned code);
    return code + 1;
  endfunction

  // True when the sub-counter has reached the last tick of its period.
  function automatic logic sub_last(input int unsigned sub, input int unsigned code);
    return (sub == code);
  endfunction

endpackage

// File: rtl/tbase_tick_mux.sv
module tbase_tick_mux (
  input  logic run,
  input  logic src_sel,
  input  logic slow_en,
  input  logic fast_en,
  output logic tmr_tick
);
  logic picked;

  always_comb begin
    picked   = src_sel ? fast_en : slow_en;
    tmr_tick = run & picked;
  end
endmodule

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tmr_tick,
  input  logic            cnt_full,
  input  logic [PS_W-1:0] ps_code,
  output logic            pre_tick,
  output logic            cycle_end,
  output logic [PS_W-1:0] sub_cnt,
  output logic [PS_W-1:0] act_code
);
  import tbase_pkg::*;

  logic at_last;

  always_comb begin
    at_last   = sub_last(int'(sub_cnt), int'(act_code));
    pre_tick  = tmr_tick & at_last;
    cycle_end = pre_tick & cnt_full;
  end

  // Sub-counter: restarts at each prescaled tick (and so at every wrap).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sub_cnt <= '0;
    else if (!run)
      sub_cnt <= '0;
    else if (tmr_tick)
      sub_cnt <= at_last ? '0 : sub_cnt + 1'b1;
  end

  // Shadowed code: direct while stopped, reloaded only at the wrap while running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_code <= '0;
    else if (!run || cycle_end)
      act_code <= ps_code;
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_tick,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_full,
  output logic             wrap_q
);
  always_comb cnt_full = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      wrap_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= pre_tick & cnt_full;
      if (pre_tick)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 12,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_sel,
  input  logic             slow_en,
  input  logic             fast_en,
  input  logic [PS_W-1:0]  ps_code,
  output logic [CNT_W-1:0] count,
  output logic             wrap_pulse,
  output logic [PS_W-1:0]  ps_active
);
  // Named internal events, visible to the bound checker.
  logic            tmr_tick;
  logic            pre_tick;
  logic            cycle_end;
  logic            cnt_full;
  logic [PS_W-1:0] sub_cnt;

  tbase_tick_mux u_mux (
    .run      (run),
    .src_sel  (src_sel),
    .slow_en  (slow_en),
    .fast_en  (fast_en),
    .tmr_tick (tmr_tick)
  );

  tbase_prescale #(.PS_W(PS_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tmr_tick  (tmr_tick),
    .cnt_full  (cnt_full),
    .ps_code   (ps_code),
    .pre_tick  (pre_tick),
    .cycle_end (cycle_end),
    .sub_cnt   (sub_cnt),
    .act_code  (ps_active)
  );

  tbase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pre_tick (pre_tick),
    .cnt      (count),
    .cnt_full (cnt_full),
    .wrap_q   (wrap_pulse)
  );
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
  parameter int CNT_W = 12,
  parameter int PS_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             src_sel,
  input logic             slow_en,
  input logic             fast_en,
  input logic [CNT_W-1:0] count,
  input logic             wrap_pulse,
  input logic [PS_W-1:0]  ps_active,
  input logic [PS_W-1:0]  sub_cnt
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !wrap_pulse) |->
      (count == $past(count) || count == $past(count) + 1'b1));

  assert_slow_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !src_sel && !slow_en) |=> (count == $past(count)));

  assert_fast_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && src_sel && !fast_en) |=> (count == $past(count)));

  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !wrap_pulse) |-> $stable(ps_active));

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (count == '0));

  assert_wrap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

  assert_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0 && sub_cnt == '0 && !wrap_pulse));

  assert_sub_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (sub_cnt == '0));
endmodule

bind pwm_timebase tbase_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .src_sel    (src_sel),
  .slow_en    (slow_en),
  .fast_en    (fast_en),
  .count      (count),
  .wrap_pulse (wrap_pulse),
  .ps_active  (ps_active),
  .sub_cnt    (sub_cnt)
);

// File: tb/sim_pwm_timebase.sv
`timescale 1ns/1ps
module sim_pwm_timebase;
  localparam int CNT_W = 12;
  localparam int PS_W  = 3;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic             src_sel = 1'b0;
  logic             slow_en = 1'b0;
  logic             fast_en = 1'b0;
  logic [PS_W-1:0]  ps_code = '0;
  logic [CNT_W-1:0] count;
  logic             wrap_pulse;
  logic [PS_W-1:0]  ps_active;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // Reference state, kept from the requirements.
  int m_cnt = 0;
  int m_sub = 0;
  int m_code = 0;
  bit m_wrap = 1'b0;

  always #2 clk = ~clk;

  pwm_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel),
    .slow_en(slow_en), .fast_en(fast_en), .ps_code(ps_code),
    .count(count), .wrap_pulse(wrap_pulse), .ps_active(ps_active)
  );

  function automatic bit ref_tick(bit s, bit se, bit fe);
    return s ? fe : se;
  endfunction

  function automatic int ref_div(int code);
    return code + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Advance reference and design by one clock, then compare.
  task automatic step();
    if (!run) begin
      m_cnt = 0; m_sub = 0; m_wrap = 1'b0; m_code = int'(ps_code);
    end else begin
      m_wrap = 1'b0;
      if (ref_tick(src_sel, slow_en, fast_en)) begin
        if (m_sub + 1 == ref_div(m_code)) begin
          m_sub = 0;
          if (m_cnt == CMAX) begin
            m_cnt = 0; m_wrap = 1'b1; m_code = int'(ps_code);
          end else begin
            m_cnt = m_cnt + 1;
          end
        end else begin
          m_sub = m_sub + 1;
        end
      end
    end
    @(posedge clk);
    #1;
    cycles++;
    chk("R2 count", int'(count), m_cnt);
    chk("R5 wrap_pulse", int'(wrap_pulse), int'(m_wrap));
    chk("R4 ps_active", int'(ps_active), m_code);
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    bit seen;
    int r;
    r = $urandom(32'd4409);

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count", int'(count), 0);
    chk("R1 wrap_pulse", int'(wrap_pulse), 0);
    chk("R1 ps_active", int'(ps_active), 0);
    rst_n = 1'b1;

    // R6: stopped, active code follows written code
    for (int i = 0; i < 8; i++) begin
      ps_code = PS_W'(i);
      slow_en = 1'b1; fast_en = 1'b1;
      step();
      chk("R6 ps_active follows", int'(ps_active), i);
      chk("R6 count held", int'(count), 0);
    end

    // R3: slow source selected, fast enable toggling must be ignored
    ps_code = 3'd0; step();
    run = 1'b1; src_sel = 1'b0;
    for (int i = 0; i < 40; i++) begin
      slow_en = (i % 3 == 0);
      fast_en = 1'b1;
      step();
    end
    chk("R3 slow count", int'(count), 14);
    src_sel = 1'b1;
    for (int i = 0; i < 40; i++) begin
      slow_en = 1'b1;
      fast_en = (i % 4 == 0);
      step();
    end
    chk("R3 fast count", int'(count), 24);

    // R4/R5: full wrap at divide 1, codes written mid-cycle
    run = 1'b0; ps_code = 3'd0; step();
    run = 1'b1; src_sel = 1'b1; fast_en = 1'b1; slow_en = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      if (i == 1000) ps_code = 3'd5;
      if (i == 2000) ps_code = 3'd2;
      step();
      if (i == 3000) chk("R4 held mid-cycle", int'(ps_active), 0);
      if (wrap_pulse) begin
        seen = 1'b1;
        chk("R5 wrap cycle index", i, CMAX);
      end
    end
    chk("R5 wrap seen", int'(seen), 1);
    chk("R4 last code loaded", int'(ps_active), 2);
    ps_code = 3'd6;

    // R7: new factor 3 starts cleanly
    step(); step();
    chk("R7 count after 2 ticks", int'(count), 0);
    step();
    chk("R7 count after 3 ticks", int'(count), 1);

    // R5: next wrap with divide 3
    seen = 1'b0;
    for (int i = 0; i < 13000 && !seen; i++) begin
      step();
      if (wrap_pulse) seen = 1'b1;
    end
    chk("R5 second wrap", int'(seen), 1);
    chk("R4 second reload", int'(ps_active), 6);
    step();
    chk("R5 pulse one cycle", int'(wrap_pulse), 0);

    // Random mix: enables, source, codes, start/stop
    for (int i = 0; i < 20000; i++) begin
      slow_en = 1'($urandom_range(0, 1));
      fast_en = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 5) ps_code = PS_W'($urandom_range(0, 7));
      if ($urandom_range(0, 299) == 0) src_sel = ~src_sel;
      if ($urandom_range(0, 499) == 0) run = ~run;
      step();
    end

    finish_run();
  end
endmodule